// File: doc/BRIEF.md
# I2C Stuck-Data Bus Recovery Sequencer

This block frees an I2C bus when a target device keeps SDA pulled low, for example after a controller reset interrupted a read in mid-byte. Software starts a recovery by writing a command word with the recover bit set. The sequencer then clocks SCL so that the target can shift out the rest of its byte and let go of SDA. It gives at least one pulse and at most a fixed number of pulses (eight by default). It stops as soon as it sees SDA high at the end of a high phase. SDA is never driven.

Pulse timing comes from an external half-period tick, so one SCL level lasts one tick interval. A target may stretch the clock: a high phase is not counted while the sampled SCL line stays low. At the end of a sequence a sticky done status bit is set, whether or not SDA was freed. Software clears that bit by writing 1 to its position in the status word. If SDA still reads low after the last pulse, recovery has failed and software sees this from the live line level. A stuck SCL line is not handled here.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset SCL and SDA are both released (`scl_drive_low`=0, `sda_drive_low`=0) and `recovery_done` is 0.
- R2: A sequence starts only on a command write (`cmd_wr`=1) whose bit 11 is 1. A command write with bit 11 at 0 produces no SCL activity.
- R3: Each pulse drives SCL low until the next `half_tick`, then releases it for at least one tick interval. Every low phase after the first lasts exactly one tick period.
- R4: SDA is sampled at the tick that ends each high phase. If it reads high, the sequence ends with SCL released and `recovery_done` set.
- R5: At least one pulse is issued, even when SDA is already high at the start.
- R6: No more than 8 pulses are issued. If SDA is still low after the eighth, the sequence still ends with SCL released and `recovery_done` set.
- R7: `recovery_done` holds until a status write (`sts_wr`=1) with bit 13 at 1 clears it. A status write with bit 13 at 0 leaves it set. Completion in the same cycle as a clear leaves it set.
- R8: A recover command written while a sequence is running is ignored, and the pulse count carries on.
- R9: SDA is never driven low.
- R10: While SCL is released but the sampled SCL line reads low (clock stretching), the high phase does not end and no further pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | 32 | Command word; bit 11 requests recovery |
| sts_wr | input | 1 | Status word write strobe |
| sts_data | input | 32 | Status word; a 1 at bit 13 clears done |
| half_tick | input | 1 | One-cycle strobe per SCL half period |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low (always 0) |
| recovery_done | output | 1 | Sticky end-of-sequence status |

## Verification
The bench models a target that lets go of SDA after a chosen number of pulses. It sweeps that number across 0, the limit and past the limit, so a design that stopped early, counted one pulse too many or never stopped would show the wrong pulse count.

Three further cases are set up directly:
- A second recover command is written mid-run at the limit. A design that restarted its count would exceed eight pulses.
- SCL is held low during a high phase. A design that ignored stretching would finish or pulse again while the line was held.
- A clear is held on across a completion. A design that gave the clear priority would never show done.

A command with the wrong bit set is also written, to catch a decoder that starts on any write.

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick #(
  parameter int WORD_W      = 32,
  parameter int RECOVER_BIT = 11,
  parameter int DONE_BIT    = 13,
  parameter int MAX_PULSES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              sts_wr,
  input  logic [WORD_W-1:0] sts_data,
  input  logic              half_tick,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              recovery_done
);
  localparam int CW = $clog2(MAX_PULSES + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          start, finish, clear;

  assign start  = cmd_wr & cmd_data[RECOVER_BIT];
  assign clear  = sts_wr & sts_data[DONE_BIT];
  assign finish = (state == S_HIGH) & half_tick & scl_in &
                  (sda_in | (cnt == CW'(MAX_PULSES)));

  assign scl_drive_low = (state == S_LOW);
  assign sda_drive_low = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state <= S_LOW;
          cnt   <= '0;
        end
        S_LOW: if (half_tick) begin
          state <= S_HIGH;
          cnt   <= cnt + 1'b1;
        end
        S_HIGH: if (half_tick && scl_in) state <= finish ? S_IDLE : S_LOW;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      recovery_done <= 1'b0;
    else if (finish) recovery_done <= 1'b1;
    else if (clear)  recovery_done <= 1'b0;
  end

  assert_cnt_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_PULSES));

  assert_done_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recovery_done) |-> (state == S_IDLE) && $past(state == S_HIGH));

  assert_rerun_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOW && !half_tick && start) |=> (state == S_LOW) && (cnt == $past(cnt)));

  assert_stretch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HIGH && !scl_in) |=> (state == S_HIGH) && !recovery_done || $past(recovery_done));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (recovery_done && clear && !finish) |=> !recovery_done);

  assert_low_ends_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> $past(half_tick));
endmodule

// File: tb/sim_i2c_bus_unstick.sv
module sim_i2c_bus_unstick;
  localparam int TICKP = 4;
  localparam int NV = 7;
  localparam int KV  [NV] = '{0, 1, 3, 7, 8, 9, 12};
  localparam int EXPV[NV] = '{1, 1, 3, 7, 8, 8, 8};

  logic clk = 0, rst_n = 0;
  logic cmd_wr = 0, sts_wr = 0, half_tick = 0, stretch = 0;
  logic [31:0] cmd_data = '0, sts_data = '0;
  logic sda_in, scl_in, drv, sda_drv, done;
  int k_cur = 100, pulses = 0, low_len = 0, bad_low = 0, tick_cnt = 0;
  int checks = 0, errors = 0, seen_done = 0;
  logic prev_drv = 0;

  always #4 clk = ~clk;

  assign sda_in = (pulses >= k_cur);
  assign scl_in = ~drv & ~stretch;

  i2c_bus_unstick u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .sts_wr(sts_wr), .sts_data(sts_data), .half_tick(half_tick),
    .sda_in(sda_in), .scl_in(scl_in), .scl_drive_low(drv),
    .sda_drive_low(sda_drv), .recovery_done(done));

  always @(negedge clk) begin
    tick_cnt  = (tick_cnt + 1) % TICKP;
    half_tick <= (tick_cnt == 0);
    if (done) seen_done = 1;
    if (drv) low_len = low_len + 1;
    if (prev_drv && !drv) begin
      if (pulses >= 1 && low_len != TICKP) bad_low = bad_low + 1;
      pulses = pulses + 1;
      low_len = 0;
    end
    prev_drv = drv;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [31:0] d);
    @(negedge clk); cmd_wr = 1; cmd_data = d;
    @(negedge clk); cmd_wr = 0; cmd_data = '0;
  endtask

  task automatic wr_sts(input logic [31:0] d);
    @(negedge clk); sts_wr = 1; sts_data = d;
    @(negedge clk); sts_wr = 0; sts_data = '0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
  endtask

  task automatic prep(input int k);
    wr_sts(32'h2000);
    k_cur = k; pulses = 0; bad_low = 0; seen_done = 0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(drv == 0 && sda_drv == 0, "R1 scl/sda released", drv, 0);
    check(done == 0, "R1 done clear", done, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // Table of target release points and expected pulse counts (R4 R5 R6)
    for (int v = 0; v < NV; v++) begin
      prep(KV[v]);
      wr_cmd(32'h0000_0800);
      wait_done();
      @(negedge clk);
      check(pulses == EXPV[v], "R4/R5/R6 pulse count", pulses, EXPV[v]);
      check(done == 1, "R4 done set", done, 1);
      check(drv == 0, "R6 scl released at end", drv, 0);
      check(bad_low == 0, "R3 low phase length", bad_low, 0);
      check(sda_drv == 0, "R9 sda never driven", sda_drv, 0);
    end

    // R7: writing 0 at bit 13 keeps done, writing 1 clears it
    wr_sts(32'hFFFF_DFFF);
    check(done == 1, "R7 clear ignored without bit 13", done, 1);
    wr_sts(32'h0000_2000);
    check(done == 0, "R7 cleared by bit 13", done, 0);

    // R2: command without bit 11 does nothing
    prep(3);
    wr_cmd(32'hFFFF_F7FF);
    repeat (30) @(negedge clk);
    check(pulses == 0 && drv == 0, "R2 no start without bit 11", pulses, 0);
    check(done == 0, "R2 no done", done, 0);

    // R8: second recover command mid-run at the limit
    prep(12);
    wr_cmd(32'h0000_0800);
    for (int i = 0; i < 500 && pulses < 3; i++) @(negedge clk);
    wr_cmd(32'h0000_0800);
    wait_done();
    @(negedge clk);
    check(pulses == 8, "R8 rerun ignored, pulse count", pulses, 8);

    // R10: clock stretching holds the high phase
    prep(2);
    stretch = 1;
    wr_cmd(32'h0000_0800);
    for (int i = 0; i < 500 && pulses < 1; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    check(pulses == 1, "R10 no pulse while stretched", pulses, 1);
    check(done == 0 && drv == 0, "R10 no end while stretched", done, 0);
    stretch = 0;
    wait_done();
    @(negedge clk);
    check(pulses == 2, "R10 resumes after stretch", pulses, 2);

    // R7: completion wins over a clear held in the same cycle
    prep(1);
    wr_cmd(32'h0000_0800);
    @(negedge clk); sts_wr = 1; sts_data = 32'h2000;
    for (int i = 0; i < 500 && pulses < 1; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    sts_wr = 0; sts_data = '0;
    @(negedge clk);
    check(seen_done == 1, "R7 set wins over clear", seen_done, 1);
    check(done == 0, "R7 clear after completion", done, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule